// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs 32-bit integer multiplication and division and keeps its results in a pair of result registers, HI and LO. A caller presents an operation code and two operands with a one-cycle `start` strobe. Multiplies complete on the next clock edge. Divides iterate for one bit per cycle while `busy` is high. Each operation ends with a one-cycle `done` pulse. Both result registers can always be read, and each can be loaded directly through its own write port.

The multiply family forms the full 64-bit product, with operands treated as signed or unsigned. The product can replace HI:LO, be added to the 64-bit value HI:LO, or be subtracted from it. A divide puts the quotient in LO and the remainder in HI. Signed division truncates toward zero.

The controller is a two-state machine:
- `ST_IDLE` accepts a new operation.
- `ST_DIV` runs the divide iterations.

It has two transitions:
- `T_DIV_BEGIN`: `ST_IDLE` to `ST_DIV`, taken when a divide with a non-zero divisor is accepted.
- `T_DIV_END`: `ST_DIV` to `ST_IDLE`, taken on the last iteration.

Every other case stays in its current state. Multiplies and divides by zero finish without leaving `ST_IDLE`.

Top module: `hilo_muldiv`

## Requirements
- R1: Operation codes 0 (signed) and 1 (unsigned) multiply `a` by `b` into a 64-bit product. HI receives the upper 32 bits and LO the lower 32 bits on the clock edge that samples `start`, and `done` is high for the cycle that follows.
- R2: Operation codes 2 (signed) and 3 (unsigned) add the 64-bit product to the old value HI:LO and write the 64-bit sum back, upper half to HI. Timing is the same as R1.
- R3: Operation codes 4 (signed) and 5 (unsigned) subtract the 64-bit product from the old value HI:LO and write the 64-bit difference back, upper half to HI. Timing is the same as R1.
- R4: Operation code 7 divides `a` by `b` as unsigned numbers. The quotient goes to LO and the remainder to HI.
- R5: Operation code 6 divides as signed numbers. The quotient truncates toward zero, and the remainder carries the sign of the dividend.
- R6: Signed division of 0x80000000 by 0xFFFFFFFF gives 0x80000000 in LO and 0 in HI.
- R7: A divide (code 6 or 7) with `b` equal to 0 raises `done` in the cycle after `start` is sampled and leaves HI and LO unchanged.
- R8: A divide with a non-zero divisor holds `busy` high for exactly 32 cycles after `start` is sampled. The results appear, and `done` pulses for one cycle, as `busy` falls.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the results nor the latency of the running divide.
- R10: When `hi_we` or `lo_we` is high, the matching register takes `hi_wdata` or `lo_wdata` at the next edge. If an operation writes that register on the same edge, the operation's result wins.
- R11: While `rst_n` is low, HI, LO, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled when not busy |
| op | input | 3 | Operation code |
| a | input | 32 | First operand (multiplicand or dividend) |
| b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Divide iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| hi_we | input | 1 | Direct write enable for HI |
| hi_wdata | input | 32 | Direct write data for HI |
| lo_we | input | 1 | Direct write enable for LO |
| lo_wdata | input | 32 | Direct write data for LO |

## Verification
The bench builds the unit at its default width of 32 bits, so the operands match the 64-bit integer arithmetic of the bench's reference functions. This width makes the full 32-iteration divide latency observable. It also brings the extreme operands within reach: 0x80000000, 0xFFFFFFFF, and products whose accumulation wraps the 64-bit HI:LO pair.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_MADD_S = 3'd2,
        OP_MADD_U = 3'd3,
        OP_MSUB_S = 3'd4,
        OP_MSUB_U = 3'd5,
        OP_DIV_S  = 3'd6,
        OP_DIV_U  = 3'd7
    } hilo_op_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } hilo_state_e;

    function automatic logic op_is_div(input logic [OPW-1:0] code);
        return code[2] & code[1];
    endfunction

    function automatic logic op_is_signed(input logic [OPW-1:0] code);
        return ~code[0];
    endfunction
endpackage

// File: rtl/hilo_mul.sv
module hilo_mul
    import hilo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    input  acc_mode_e      mode,
    input  logic [2*W-1:0] acc,
    output logic [2*W-1:0] res
);
    localparam int PW = 2 * W;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;

    // Extend operands to full product width; truncated product is exact mod 2^PW.
    assign a_ext = {{W{sgn & a[W-1]}}, a};
    assign b_ext = {{W{sgn & b[W-1]}}, b};
    assign prod  = a_ext * b_ext;

    always_comb begin
        unique case (mode)
            ACC_ADD: res = acc + prod;
            ACC_SUB: res = acc - prod;
            default: res = prod;
        endcase
    end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] q_nxt,
    output logic [W-1:0] r_nxt
);
    logic [W-1:0] quo_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   trial;
    logic [W:0]   diff;

    // One restoring iteration: shift in the next dividend bit, try a subtract.
    assign trial = {rem_q, quo_q[W-1]};
    assign diff  = trial - {1'b0, dvs_q};

    always_comb begin
        if (!diff[W]) begin
            r_nxt = diff[W-1:0];
            q_nxt = {quo_q[W-2:0], 1'b1};
        end else begin
            r_nxt = trial[W-1:0];
            q_nxt = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            quo_q <= dvd;
            rem_q <= '0;
            dvs_q <= dvs;
        end else if (step) begin
            quo_q <= q_nxt;
            rem_q <= r_nxt;
        end
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo,
    input  logic           hi_we,
    input  logic [W-1:0]   hi_wdata,
    input  logic           lo_we,
    input  logic [W-1:0]   lo_wdata
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_IT = CW'(W - 1);

    hilo_state_e state_q, state_d;
    logic [CW-1:0]  it_q;
    logic [W-1:0]   hi_q, lo_q;
    logic           done_q;
    logic           q_neg_q, r_neg_q;

    logic           accept, div_op, sgn, b_zero, div_go, last_it;
    acc_mode_e      mode;
    logic [2*W-1:0] mul_res;
    logic           a_neg, b_neg;
    logic [W-1:0]   a_mag, b_mag;
    logic [W-1:0]   q_nxt, r_nxt;

    assign accept  = start && (state_q == ST_IDLE);
    assign div_op  = op_is_div(op);
    assign sgn     = op_is_signed(op);
    assign b_zero  = (b == '0);
    assign div_go  = accept && div_op && !b_zero;
    assign last_it = (state_q == ST_DIV) && (it_q == LAST_IT);

    always_comb begin
        unique case (hilo_op_e'(op))
            OP_MADD_S, OP_MADD_U: mode = ACC_ADD;
            OP_MSUB_S, OP_MSUB_U: mode = ACC_SUB;
            default:              mode = ACC_NONE;
        endcase
    end

    hilo_mul #(.W(W)) u_mul (
        .a    (a),
        .b    (b),
        .sgn  (sgn),
        .mode (mode),
        .acc  ({hi_q, lo_q}),
        .res  (mul_res)
    );

    // Divide on magnitudes; signs restored on the final iteration.
    assign a_neg = sgn & a[W-1];
    assign b_neg = sgn & b[W-1];
    assign a_mag = a_neg ? (~a + 1'b1) : a;
    assign b_mag = b_neg ? (~b + 1'b1) : b;

    hilo_div #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_go),
        .step  (state_q == ST_DIV),
        .dvd   (a_mag),
        .dvs   (b_mag),
        .q_nxt (q_nxt),
        .r_nxt (r_nxt)
    );

    // Next-state logic: T_DIV_BEGIN and T_DIV_END.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (div_go)  state_d = ST_DIV;
            ST_DIV:  if (last_it) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            it_q    <= '0;
            q_neg_q <= 1'b0;
            r_neg_q <= 1'b0;
        end else begin
            done_q <= (accept && (!div_op || b_zero)) || last_it;
            if (hi_we) hi_q <= hi_wdata;
            if (lo_we) lo_q <= lo_wdata;
            if (div_go) begin
                it_q    <= '0;
                q_neg_q <= a_neg ^ b_neg;
                r_neg_q <= a_neg;
            end else if (state_q == ST_DIV) begin
                it_q <= it_q + 1'b1;
            end
            if (accept && !div_op) begin
                hi_q <= mul_res[2*W-1:W];
                lo_q <= mul_res[W-1:0];
            end else if (last_it) begin
                lo_q <= q_neg_q ? (~q_nxt + 1'b1) : q_nxt;
                hi_q <= r_neg_q ? (~r_nxt + 1'b1) : r_nxt;
            end
        end
    end

    assign busy = (state_q == ST_DIV);
    assign done = done_q;
    assign hi   = hi_q;
    assign lo   = lo_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk
    import hilo_pkg::*;
#(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [OPW-1:0] op,
    input logic [W-1:0]   b,
    input logic           busy,
    input logic           done,
    input logic [W-1:0]   hi,
    input logic [W-1:0]   lo,
    input logic           hi_we,
    input logic           lo_we
);
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + 1'b1;
    end

    p_mul_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_is_div(op)) |=> (done && !busy));

    p_div_zero_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_is_div(op) && b == '0 && !hi_we && !lo_we)
            |=> (done && $stable(hi) && $stable(lo)));

    p_div_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 32'(W) && done));

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && busy_len < 32'(W - 1)) |=> (busy && !done));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .b     (b),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo),
    .hi_we (hi_we),
    .lo_we (lo_we)
);

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic        busy, done;
    logic [31:0] hi, lo;
    logic        hi_we = 1'b0, lo_we = 1'b0;
    logic [31:0] hi_wdata = '0, lo_wdata = '0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ehi = '0, elo = '0;

    always #5 clk = ~clk;

    hilo_muldiv #(.W(32)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .busy(busy), .done(done), .hi(hi), .lo(lo),
        .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: return "R1";
            3'd2, 3'd3: return "R2";
            3'd4, 3'd5: return "R3";
            3'd6:       return "R5";
            default:    return "R4";
        endcase
    endfunction

    // Reference model updating ehi/elo from the requirements.
    task automatic model(input logic [2:0] code, input logic [31:0] x, input logic [31:0] y);
        longint p, q, r;
        logic [63:0] acc;
        acc = {ehi, elo};
        if (code <= 3'd5) begin
            if (!code[0]) p = longint'($signed(x)) * longint'($signed(y));
            else          p = longint'(x) * longint'(y);
            if (code >= 3'd4)      acc = acc - 64'(p);
            else if (code >= 3'd2) acc = acc + 64'(p);
            else                   acc = 64'(p);
            ehi = acc[63:32];
            elo = acc[31:0];
        end else if (y != 0) begin
            if (code == 3'd6) begin
                q = longint'($signed(x)) / longint'($signed(y));
                r = longint'($signed(x)) % longint'($signed(y));
            end else begin
                q = longint'(x) / longint'(y);
                r = longint'(x) % longint'(y);
            end
            elo = q[31:0];
            ehi = r[31:0];
        end
    endtask

    task automatic run_op(input logic [2:0] code, input logic [31:0] x, input logic [31:0] y,
                          output int lat);
        @(negedge clk);
        start = 1'b1; op = code; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_and_check(input logic [2:0] code, input logic [31:0] x, input logic [31:0] y);
        int lat;
        int exp_lat;
        exp_lat = (code >= 3'd6 && y != 0) ? 33 : 1;
        run_op(code, x, y, lat);
        model(code, x, y);
        if (code >= 3'd6 && y == 0) begin
            check("R7 hi", {32'd0, hi}, {32'd0, ehi});
            check("R7 lo", {32'd0, lo}, {32'd0, elo});
            check("R7 latency", 64'(lat), 64'(exp_lat));
        end else begin
            check(req_of(code), {hi, lo}, {ehi, elo});
            check(code >= 3'd6 ? "R8 latency" : "R1 latency", 64'(lat), 64'(exp_lat));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {busy, done, hi, lo}, '0);
        rst_n = 1'b1;

        // Directed: R1 multiply
        do_and_check(3'd0, 32'hFFFF_FFFD, 32'd7);
        do_and_check(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_and_check(3'd0, 32'h8000_0000, 32'h8000_0000);
        // R2 accumulate, R3 subtract
        do_and_check(3'd3, 32'hFFFF_FFFF, 32'h0000_0002);
        do_and_check(3'd2, 32'hFFFF_FFFF, 32'h0000_0005);
        do_and_check(3'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        do_and_check(3'd5, 32'hFFFF_FFFF, 32'h1234_5678);
        // R4 unsigned divide
        do_and_check(3'd7, 32'd100, 32'd7);
        do_and_check(3'd7, 32'hFFFF_FFFF, 32'd1);
        // R5 signed divide truncation toward zero
        do_and_check(3'd6, 32'hFFFF_FFF9, 32'd2);
        check("R5 quotient -3", {32'd0, lo}, {32'd0, 32'hFFFF_FFFD});
        check("R5 remainder -1", {32'd0, hi}, {32'd0, 32'hFFFF_FFFF});
        do_and_check(3'd6, 32'd7, 32'hFFFF_FFFE);
        // R6 most negative by -1
        do_and_check(3'd6, 32'h8000_0000, 32'hFFFF_FFFF);
        check("R6", {hi, lo}, {32'h0, 32'h8000_0000});
        // R7 divide by zero, both forms
        do_and_check(3'd6, 32'd55, 32'd0);
        do_and_check(3'd7, 32'd55, 32'd0);

        // R9: start while busy is ignored
        @(negedge clk);
        start = 1'b1; op = 3'd7; a = 32'd1000; b = 32'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; op = 3'd1; a = 32'd5; b = 32'd5;
        @(negedge clk);
        start = 1'b0;
        check("R9 no early done", {63'd0, done}, 64'd0);
        lat = 6;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        model(3'd7, 32'd1000, 32'd3);
        check("R9 result", {hi, lo}, {ehi, elo});
        check("R9 latency", 64'(lat), 64'd33);
        @(negedge clk);
        check("R9 single done", {63'd0, done}, 64'd0);

        // R10: direct writes
        hi_we = 1'b1; hi_wdata = 32'hDEAD_BEEF;
        lo_we = 1'b1; lo_wdata = 32'h0000_0010;
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
        ehi = 32'hDEAD_BEEF; elo = 32'h0000_0010;
        check("R10 direct", {hi, lo}, {ehi, elo});
        do_and_check(3'd3, 32'd2, 32'd3);
        // R10: same-edge conflict, operation wins
        @(negedge clk);
        start = 1'b1; op = 3'd1; a = 32'd9; b = 32'd9;
        hi_we = 1'b1; hi_wdata = 32'h5555_5555;
        lo_we = 1'b1; lo_wdata = 32'hAAAA_AAAA;
        @(negedge clk);
        start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
        check("R10 op wins", {hi, lo}, {32'd0, 32'd81});
        ehi = 32'd0; elo = 32'd81;

        // Constrained random mix
        for (int i = 0; i < 150; i++) begin
            logic [2:0]  c;
            logic [31:0] x, y;
            c = 3'($urandom % 8);
            case ($urandom % 4)
                0: x = 32'h8000_0000;
                1: x = 32'($urandom % 64);
                default: x = $urandom;
            endcase
            case ($urandom % 5)
                0: y = 32'd0;
                1: y = 32'hFFFF_FFFF;
                2: y = 32'($urandom % 16);
                default: y = $urandom;
            endcase
            do_and_check(c, x, y);
        end

        finish_run();
    end
endmodule